// File: doc/BRIEF.md
# Carry-Save Feedback Queue with Binary Conversion

This block sits on the return path of a word-serial modular multiplier built as a chain of processing elements. Each result word leaving the last element arrives in carry-save form: a W-bit sum vector and a W-bit carry vector of the same bit weights. The block decides what the first element of the chain sees next. At the start of an operation it sees a zero word. If the first element is ready and nothing is waiting, the redundant word passes straight through with no adder on the path. Otherwise the word is turned into ordinary binary and stored in a FIFO whose entries are only W bits wide.

Every accepted word is also converted to binary and leaves on a result port one cycle later. The carry-propagate adder works on one word per cycle, least significant word first. It holds its carry-out in a register and adds it into the next word. A new operation clears that register.

Queued words go back to the first element with an all-zero carry vector, so that element always receives a carry-save pair. When the FIFO is full, the block stops accepting words from the last element.

Top module: `csq_feedback_queue`

## Requirements
- R1: After reset, with `op_start`, `in_valid` and `fe_ready` low, the block shows `q_empty`=1, `q_full`=0, `in_ready`=1, `fe_valid`=0 and `res_valid`=0.
- R2: While `op_start` is high, `fe_valid`=1 with `fe_sum`=0 and `fe_carry`=0. A word accepted in that same cycle is converted with a carry-in of 0.
- R3: When `op_start` is low, the FIFO is empty, and `in_valid` and `fe_ready` are high, the block passes the input through in the same cycle: `fe_sum`=`in_sum`, `fe_carry`=`in_carry` and `fe_valid`=1.
- R4: One cycle after a word is accepted (`in_valid` and `in_ready`), `res_valid`=1 and `res_word` equals (`in_sum` + `in_carry` + cin) mod 2^W. Here cin is bit W of the previous accepted word's sum, or 0 for the first word after `op_start`.
- R5: A word taken from the FIFO is shown with `fe_sum` set to its converted binary value and `fe_carry`=0.
- R6: An accepted word is stored when `fe_ready` is low, when `op_start` is high, or when the FIFO holds entries. Words reach the first element in arrival order.
- R7: `q_full` is 1 when DEPTH words are stored, and then `in_ready`=0. A word offered while `in_ready`=0 is neither stored nor converted.
- R8: When `op_start` is low and either `fe_ready` is low, or the FIFO is empty and `in_valid` is low, `fe_valid`=0.
- R9: A cycle that both takes a word from the FIFO and stores one leaves the number of stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | First cycle of an operation |
| in_valid | input | 1 | Last element offers a word |
| in_sum | input | W | Sum vector of offered word |
| in_carry | input | W | Carry vector of offered word (same weights) |
| in_ready | output | 1 | Block can accept a word |
| fe_ready | input | 1 | First element can take a word |
| fe_valid | output | 1 | Word presented to first element |
| fe_sum | output | W | Sum vector to first element |
| fe_carry | output | W | Carry vector to first element |
| res_valid | output | 1 | Converted result word valid |
| res_word | output | W | Converted binary result word |
| q_full | output | 1 | FIFO holds DEPTH words |
| q_empty | output | 1 | FIFO holds no word |

## Verification
The stimulus covers four situations. In the first, the first element is always ready, so every word should take the bypass path unchanged. In the second, words arrive while the first element is stalled, which fills the FIFO to full and then offers one extra word that must be refused. In the third, the FIFO drains while new words keep arriving, so a word is stored and one removed in the same cycle. In the last, `op_start` is pulsed while words are in flight. The operand values are chosen so that the adder produces a carry-out before `op_start` and before the next word. This exposes a carry that is not passed on to the next word, and it also exposes a carry that is not cleared when an operation starts. Comparing the bypass words with the queued words shows whether the multiplexer picked the right source and whether queued words carry a zero carry vector.

// File: rtl/csq_pkg.sv
// Shared types for the carry-save feedback queue.
package csq_pkg;
    // Source selected for the first processing element.
    typedef enum logic [1:0] {
        SEL_ZERO   = 2'd0,
        SEL_BYPASS = 2'd1,
        SEL_QUEUE  = 2'd2,
        SEL_NONE   = 2'd3
    } fe_sel_e;
endpackage

// File: rtl/csq_cpa.sv
// Word-serial carry-propagate converter.
// Adds the sum vector, the carry vector and the carry kept from the previous word.
// Result is registered; the carry-out register is cleared by 'clear'.
// Assumes words arrive least significant word first within an operation.
module csq_cpa #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         valid,
    input  logic [W-1:0] sum_v,
    input  logic [W-1:0] carry_v,
    output logic [W-1:0] conv_word,
    output logic         res_valid,
    output logic [W-1:0] res_word
);
    logic         carry_q;
    logic         cin;
    logic         cout;

    // Full-width add with the chained carry-in.
    always_comb begin
        cin = clear ? 1'b0 : carry_q;
        {cout, conv_word} = {1'b0, sum_v} + {1'b0, carry_v} + {{W{1'b0}}, cin};
    end

    // Register the result and keep the carry-out for the next word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q   <= 1'b0;
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            res_valid <= valid;
            if (valid) begin
                res_word <= conv_word;
                carry_q  <= cout;
            end else if (clear) begin
                carry_q  <= 1'b0;
            end
        end
    end

    assert_result_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (res_valid && res_word == $past(conv_word)));
endmodule

// File: rtl/csq_fifo.sv
// FIFO of converted binary words with full and empty flags.
// Assumes the controller never pushes when full nor pops when empty.
module csq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    assert_count_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (count == $past(count)));
endmodule

// File: rtl/csq_ctrl.sv
// Source selection and handshake control.
// Zero has priority at operation start; the queue is served before bypass to keep order.
module csq_ctrl
    import csq_pkg::*;
(
    input  logic    op_start,
    input  logic    in_valid,
    input  logic    fe_ready,
    input  logic    q_empty,
    input  logic    q_full,
    output fe_sel_e sel,
    output logic    in_ready,
    output logic    accept,
    output logic    push,
    output logic    pop
);
    // Choose the first element's source and derive queue strobes.
    always_comb begin
        in_ready = !q_full;
        accept   = in_valid && in_ready;
        if (op_start)                   sel = SEL_ZERO;
        else if (fe_ready && !q_empty)  sel = SEL_QUEUE;
        else if (fe_ready && in_valid)  sel = SEL_BYPASS;
        else                            sel = SEL_NONE;
        pop  = (sel == SEL_QUEUE);
        push = accept && (sel != SEL_BYPASS);
    end
endmodule

// File: rtl/csq_mux.sv
// Three-way source multiplexer feeding the first processing element.
// Queued words are binary, so their carry vector is driven to zero.
module csq_mux
    import csq_pkg::*;
#(
    parameter int W = 16
) (
    input  fe_sel_e      sel,
    input  logic [W-1:0] in_sum,
    input  logic [W-1:0] in_carry,
    input  logic [W-1:0] q_word,
    output logic         fe_valid,
    output logic [W-1:0] fe_sum,
    output logic [W-1:0] fe_carry
);
    // Route the selected source.
    always_comb begin
        fe_valid = 1'b1;
        fe_sum   = '0;
        fe_carry = '0;
        case (sel)
            SEL_ZERO:   ;
            SEL_BYPASS: begin fe_sum = in_sum; fe_carry = in_carry; end
            SEL_QUEUE:  fe_sum = q_word;
            default:    fe_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/csq_feedback_queue.sv
// Feedback stage between the last and first elements of a word-serial multiplier.
// Converts every accepted carry-save word to binary, queues it when the first
// element cannot take the word now, and bypasses it when the first element is free.
// Assumes the first element takes the zero word during op_start.
module csq_feedback_queue
    import csq_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_start,
    input  logic         in_valid,
    input  logic [W-1:0] in_sum,
    input  logic [W-1:0] in_carry,
    output logic         in_ready,
    input  logic         fe_ready,
    output logic         fe_valid,
    output logic [W-1:0] fe_sum,
    output logic [W-1:0] fe_carry,
    output logic         res_valid,
    output logic [W-1:0] res_word,
    output logic         q_full,
    output logic         q_empty
);
    fe_sel_e      sel;
    logic         accept;
    logic         push;
    logic         pop;
    logic [W-1:0] conv_word;
    logic [W-1:0] q_word;

    csq_ctrl u_ctrl (
        .op_start (op_start),
        .in_valid (in_valid),
        .fe_ready (fe_ready),
        .q_empty  (q_empty),
        .q_full   (q_full),
        .sel      (sel),
        .in_ready (in_ready),
        .accept   (accept),
        .push     (push),
        .pop      (pop)
    );

    csq_cpa #(.W(W)) u_cpa (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (op_start),
        .valid     (accept),
        .sum_v     (in_sum),
        .carry_v   (in_carry),
        .conv_word (conv_word),
        .res_valid (res_valid),
        .res_word  (res_word)
    );

    csq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (conv_word),
        .dout  (q_word),
        .full  (q_full),
        .empty (q_empty)
    );

    csq_mux #(.W(W)) u_mux (
        .sel      (sel),
        .in_sum   (in_sum),
        .in_carry (in_carry),
        .q_word   (q_word),
        .fe_valid (fe_valid),
        .fe_sum   (fe_sum),
        .fe_carry (fe_carry)
    );

    assert_zero_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> (fe_valid && fe_sum == '0 && fe_carry == '0));
    assert_queue_carry_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_QUEUE) |-> (fe_carry == '0 && fe_sum == q_word));
    assert_bypass_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_BYPASS) |-> (q_empty && fe_sum == in_sum && fe_carry == in_carry));
    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !in_ready);
endmodule

// File: tb/csq_feedback_queue_tb.sv
// Scoreboard bench: the driver models expected words, the monitor checks results.
module csq_feedback_queue_tb_top;
    localparam int W     = 8;
    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_start = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_sum = '0;
    logic [W-1:0] in_carry = '0;
    logic         fe_ready = 1'b0;
    logic         in_ready, fe_valid, res_valid, q_full, q_empty;
    logic [W-1:0] fe_sum, fe_carry, res_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    logic [W-1:0] mq[$];
    logic [W-1:0] exp_res[$];
    logic         mcarry = 1'b0;

    always #4 clk = ~clk;

    csq_feedback_queue #(.W(W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .in_valid(in_valid),
        .in_sum(in_sum), .in_carry(in_carry), .in_ready(in_ready),
        .fe_ready(fe_ready), .fe_valid(fe_valid), .fe_sum(fe_sum),
        .fe_carry(fe_carry), .res_valid(res_valid), .res_word(res_word),
        .q_full(q_full), .q_empty(q_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle, check same-cycle outputs against the model, update model.
    task automatic step(input logic st, input logic iv, input logic [W-1:0] s,
                        input logic [W-1:0] c, input logic fr);
        logic       e_ready, byp, deq, acc, cin, co;
        logic [W-1:0] conv, e_sum, e_car;
        logic       e_val;
        @(negedge clk);
        op_start = st; in_valid = iv; in_sum = s; in_carry = c; fe_ready = fr;
        #1;
        e_ready = (mq.size() < DEPTH);
        deq = !st && fr && (mq.size() > 0);
        byp = !st && fr && iv && (mq.size() == 0);
        acc = iv && e_ready;
        cin = st ? 1'b0 : mcarry;
        {co, conv} = {1'b0, s} + {1'b0, c} + {{W{1'b0}}, cin};
        e_val = 1'b1; e_sum = '0; e_car = '0;
        if (st) begin end
        else if (deq) e_sum = mq[0];
        else if (byp) begin e_sum = s; e_car = c; end
        else e_val = 1'b0;
        chk(fe_valid == e_val, st ? "R2" : (e_val ? "R3/R5" : "R8"), fe_valid, e_val);
        if (e_val) begin
            chk(fe_sum == e_sum, st ? "R2" : (deq ? "R5/R6" : "R3"), fe_sum, e_sum);
            chk(fe_carry == e_car, st ? "R2" : (deq ? "R5" : "R3"), fe_carry, e_car);
        end
        chk(in_ready == e_ready, "R7", in_ready, e_ready);
        chk(q_full == (mq.size() == DEPTH), "R7", q_full, mq.size() == DEPTH);
        chk(q_empty == (mq.size() == 0), "R6", q_empty, mq.size() == 0);
        if (deq) void'(mq.pop_front());
        if (acc && !byp) mq.push_back(conv);
        if (acc) begin mcarry = co; exp_res.push_back(conv); end
        else if (st) mcarry = 1'b0;
    endtask

    // Monitor: converted results appear one cycle after acceptance (R4).
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            if (res_valid) begin
                if (exp_res.size() == 0) chk(1'b0, "R4/R7", 1, 0);
                else begin
                    logic [W-1:0] e;
                    e = exp_res.pop_front();
                    chk(res_word == e, "R4", res_word, e);
                end
            end else if (exp_res.size() > 0) begin
                chk(1'b0, "R4", 0, 1);
                void'(exp_res.pop_front());
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(q_empty == 1'b1, "R1", q_empty, 1);
        chk(q_full == 1'b0, "R1", q_full, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        chk(fe_valid == 1'b0, "R1", fe_valid, 0);
        chk(res_valid == 1'b0, "R1", res_valid, 0);
        mon_on = 1'b1;

        // R2 operation start, then bypass with carry chaining (R3, R4)
        step(1, 0, 8'h00, 8'h00, 1);
        step(0, 1, 8'hFF, 8'h01, 1);   // 0x00, carry-out 1
        step(0, 1, 8'h10, 8'h20, 1);   // 0x31
        step(0, 1, 8'h80, 8'h80, 1);   // 0x00, carry-out 1
        // R2: start with a word in same cycle, carry cleared, word queued (R6)
        step(1, 1, 8'h05, 8'h06, 1);   // 0x0B, not 0x0C
        step(0, 0, 8'h00, 8'h00, 1);   // drain queued word (R5)
        step(0, 0, 8'h00, 8'h00, 0);   // R8 idle
        // Fill queue while first element stalled (R6, R7)
        step(0, 1, 8'hF0, 8'h20, 0);   // 0x10, co 1
        step(0, 1, 8'h01, 8'h01, 0);   // 0x03
        step(0, 1, 8'h7F, 8'h7F, 0);   // 0xFE
        step(0, 1, 8'hAA, 8'h55, 0);   // 0xFF
        step(0, 1, 8'h33, 8'h33, 0);   // refused: full (R7)
        step(0, 1, 8'h33, 8'h33, 1);   // pop one, still refused this cycle
        // R9: simultaneous push and pop
        step(0, 1, 8'h01, 8'h02, 1);
        step(0, 1, 8'h04, 8'h04, 1);
        step(0, 0, 8'h00, 8'h00, 1);
        step(0, 0, 8'h00, 8'h00, 1);
        step(0, 0, 8'h00, 8'h00, 1);
        step(0, 0, 8'h00, 8'h00, 1);
        // R8: queue empty, no input
        step(0, 0, 8'h00, 8'h00, 1);
        // Back to bypass
        step(0, 1, 8'hC3, 8'h3C, 1);
        step(0, 0, 8'h00, 8'h00, 0);
        step(0, 0, 8'h00, 8'h00, 0);
        chk(q_empty == 1'b1 && exp_res.size() == 0, "R6", q_empty, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule